// File: doc/BRIEF.md
# Sequenced Small-Float Multiplier

This block multiplies two 12-bit floating-point numbers over several clock cycles. Each operand and the result hold a sign bit in the MSB, then a 5-bit biased exponent, then a 6-bit fraction with a hidden leading one. A control state machine handles the work in order. It captures the operands and starts a sequential radix-2 Booth multiplier on the two 7-bit significands. It keeps the 14-bit raw product in an intermediate register, then normalizes and packs the result into a registered output and raises `done`.

A user pulses `en` for one cycle and presents the operands on the next cycle. The block then runs without further input until `done` goes high. The result and `done` hold until the next `en` pulse. An `en` pulse that arrives while an operation is in flight is ignored. When either operand has a zero exponent field, the multiplier is skipped and a signed zero is produced at once. Rounding is by truncation. Results too small for the format flush to zero, and results too large saturate to the largest finite value.

Top module: `small_float_mul`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `done` is 0 and `out` is 12'h000.
- R2: The operands are sampled from `a` and `b` on the clock edge one cycle after the edge that samples `en` high. Their values on the `en` cycle, and any values after that capture, have no effect on the result.
- R3: The result sign (bit 11) is the XOR of the operand sign bits, including for zero, flushed and saturated results.
- R4: For normal operands (exponent in bits 10:6 and fraction in bits 5:0, bias 15), P is the product of the two 7-bit significands {1,fraction}. The exponent is ea+eb-15, plus 1 when P bit 13 is set. The fraction is P[12:7] when bit 13 is set and P[11:6] otherwise, truncated.
- R5: When the computed exponent is below 1, the result is a signed zero (exponent and fraction fields all zero).
- R6: When the computed exponent is above 30, the result is exponent 30 with fraction 6'h3F.
- R7: When either operand has exponent field 0, the result is a signed zero. `done` rises 2 clock edges after the edge that samples `en`, and the multiplier is not used.
- R8: For two nonzero operands, `done` rises 12 clock edges after the edge that samples `en` (2 capture and start edges, 8 Booth steps, 2 store and pack edges).
- R9: Once high, `done` stays high and `out` stays stable until an edge samples `en` high. At that edge `done` falls.
- R10: An `en` pulse while an operation is in progress is ignored. The result and latency of the running operation do not change.
- R11: The Booth multiplier's product equals the unsigned product of the two captured significands when it signals ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Start strobe; operands follow on the next cycle |
| a | input | 12 | First operand {sign, exponent, fraction} |
| b | input | 12 | Second operand {sign, exponent, fraction} |
| done | output | 1 | High while `out` holds a valid result |
| out | output | 12 | Registered product {sign, exponent, fraction} |

## Verification
The bench builds the block with its default widths: a 5-bit exponent and a 6-bit fraction, which give a 7-step-plus-sign Booth loop of 8 cycles. This format is small enough that random 12-bit operands often fall into flush-to-zero, saturation and zero-exponent cases, as well as the two normalization paths. The known 12-cycle and 2-cycle latencies let the bench check the timing of each operation as well as its value, and check that stray strobes during a multiply change neither.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_START,
    ST_MULT,
    ST_PACK,
    ST_DONE
  } fpm_state_t;

endpackage

// File: rtl/booth_mul_seq.sv
module booth_mul_seq #(
  parameter int N = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           ready,
  output logic [2*N-1:0] product
);

  localparam int M  = N + 1;
  localparam int CW = $clog2(M + 1);

  logic [M:0]    acc;
  logic [M:0]    mc;
  logic [M-1:0]  q;
  logic          q_prev;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [M:0]    sum;
  logic [2*M-1:0] full;

  always_comb begin
    case ({q[0], q_prev})
      2'b01:   sum = acc + mc;
      2'b10:   sum = acc - mc;
      default: sum = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mc     <= '0;
      q      <= '0;
      q_prev <= 1'b0;
      cnt    <= '0;
      busy   <= 1'b0;
      ready  <= 1'b0;
    end else if (start) begin
      acc    <= '0;
      mc     <= {2'b00, mcand};
      q      <= {1'b0, mplier};
      q_prev <= 1'b0;
      cnt    <= CW'(M);
      busy   <= 1'b1;
      ready  <= 1'b0;
    end else if (busy) begin
      acc    <= {sum[M], sum[M:1]};
      q      <= {sum[0], q[M-1:1]};
      q_prev <= q[0];
      cnt    <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy  <= 1'b0;
        ready <= 1'b1;
      end
    end
  end

  assign full    = {acc[M-1:0], q};
  assign product = full[2*N-1:0];

endmodule

// File: rtl/fpm_pack.sv
module fpm_pack #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 6
) (
  input  logic                     sign,
  input  logic [EXP_W-1:0]         exp_a,
  input  logic [EXP_W-1:0]         exp_b,
  input  logic [2*(MAN_W+1)-1:0]   prod,
  output logic [EXP_W+MAN_W:0]     res
);

  localparam int SW   = MAN_W + 1;
  localparam int EW2  = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 2;
  localparam logic signed [EW2-1:0] BIAS_S = EW2'(BIAS);
  localparam logic signed [EW2-1:0] EMAX_S = EW2'(EMAX);
  localparam logic signed [EW2-1:0] ONE_S  = EW2'(1);

  logic                    top;
  logic signed [EW2-1:0]   e_sum;
  logic [MAN_W-1:0]        mant;

  assign top   = prod[2*SW-1];
  assign e_sum = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b}) - BIAS_S
               + $signed({{(EW2-1){1'b0}}, top});
  assign mant  = top ? prod[2*SW-2 -: MAN_W] : prod[2*SW-3 -: MAN_W];

  always_comb begin
    if (e_sum < ONE_S) begin
      res = {sign, {(EXP_W+MAN_W){1'b0}}};
    end else if (e_sum > EMAX_S) begin
      res = {sign, EMAX_S[EXP_W-1:0], {MAN_W{1'b1}}};
    end else begin
      res = {sign, e_sum[EXP_W-1:0], mant};
    end
  end

endmodule

// File: rtl/small_float_mul.sv
module small_float_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [EXP_W+MAN_W:0]   a,
  input  logic [EXP_W+MAN_W:0]   b,
  output logic                   done,
  output logic [EXP_W+MAN_W:0]   out
);

  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int SW = MAN_W + 1;
  localparam int PW = 2 * SW;

  fpm_state_t     state;
  logic [W-1:0]   a_q;
  logic [W-1:0]   b_q;
  logic [PW-1:0]  mul_q;
  logic [W-1:0]   res_q;
  logic           mul_start;
  logic           mul_ready;
  logic [PW-1:0]  mul_prod;
  logic [W-1:0]   pack_res;
  logic           zero_op;
  logic           sign_r;

  assign sign_r    = a_q[W-1] ^ b_q[W-1];
  assign zero_op   = (a_q[W-2 -: EXP_W] == '0) || (b_q[W-2 -: EXP_W] == '0);
  assign mul_start = (state == ST_START) && !zero_op;

  booth_mul_seq #(.N(SW)) booth_i (
    .clk     (clk),
    .rst     (rst),
    .start   (mul_start),
    .mcand   ({1'b1, a_q[MAN_W-1:0]}),
    .mplier  ({1'b1, b_q[MAN_W-1:0]}),
    .ready   (mul_ready),
    .product (mul_prod)
  );

  fpm_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) pack_i (
    .sign  (sign_r),
    .exp_a (a_q[W-2 -: EXP_W]),
    .exp_b (b_q[W-2 -: EXP_W]),
    .prod  (mul_q),
    .res   (pack_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      a_q   <= '0;
      b_q   <= '0;
      mul_q <= '0;
      res_q <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (en) state <= ST_LOAD;
        end
        ST_LOAD: begin
          a_q   <= a;
          b_q   <= b;
          state <= ST_START;
        end
        ST_START: begin
          if (zero_op) begin
            res_q <= {sign_r, {(W-1){1'b0}}};
            done  <= 1'b1;
            state <= ST_DONE;
          end else begin
            state <= ST_MULT;
          end
        end
        ST_MULT: begin
          if (mul_ready) begin
            mul_q <= mul_prod;
            state <= ST_PACK;
          end
        end
        ST_PACK: begin
          res_q <= pack_res;
          done  <= 1'b1;
          state <= ST_DONE;
        end
        ST_DONE: begin
          if (en) begin
            done  <= 1'b0;
            state <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out = res_q;

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       en,
  input logic                       done,
  input logic [EXP_W+MAN_W:0]       out,
  input logic [EXP_W+MAN_W:0]       a_q,
  input logic [EXP_W+MAN_W:0]       b_q,
  input logic                       mul_ready,
  input logic [2*(MAN_W+1)-1:0]     mul_prod
);

  localparam int W = 1 + EXP_W + MAN_W;

  a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !en) |=> (done && $stable(out)));

  a_r9_done_clear: assert property (@(posedge clk) disable iff (rst)
    (done && en) |=> !done);

  a_r3_sign_xor: assert property (@(posedge clk) disable iff (rst)
    done |-> (out[W-1] == (a_q[W-1] ^ b_q[W-1])));

  a_r5_zero_clean: assert property (@(posedge clk) disable iff (rst)
    (done && out[W-2 -: EXP_W] == '0) |-> (out[MAN_W-1:0] == '0));

  a_r6_exp_bounded: assert property (@(posedge clk) disable iff (rst)
    done |-> (out[W-2 -: EXP_W] != {EXP_W{1'b1}}));

  a_r11_booth_product: assert property (@(posedge clk) disable iff (rst)
    $rose(mul_ready) |->
      (mul_prod == ({1'b1, a_q[MAN_W-1:0]} * {1'b1, b_q[MAN_W-1:0]})));

endmodule

bind small_float_mul fpm_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .done      (done),
  .out       (out),
  .a_q       (a_q),
  .b_q       (b_q),
  .mul_ready (mul_ready),
  .mul_prod  (mul_prod)
);

// File: tb/small_float_mul_tb.sv
module small_float_mul_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [11:0] a   = '0;
  logic [11:0] b   = '0;
  logic        done;
  logic [11:0] out;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  small_float_mul #(.EXP_W(5), .MAN_W(6)) dut_i (
    .clk(clk), .rst(rst), .en(en), .a(a), .b(b), .done(done), .out(out)
  );

  function automatic logic [11:0] ref_mul(input logic [11:0] x, input logic [11:0] y);
    int ex, ey, p, e, m;
    logic s;
    s  = x[11] ^ y[11];
    ex = int'(x[10:6]);
    ey = int'(y[10:6]);
    if (ex == 0 || ey == 0) return {s, 11'd0};
    p = (64 + int'(x[5:0])) * (64 + int'(y[5:0]));
    e = ex + ey - 15;
    if (p >= 8192) begin e = e + 1; m = (p >> 7) & 63; end
    else           m = (p >> 6) & 63;
    if (e < 1)  return {s, 11'd0};
    if (e > 30) return {s, 5'd30, 6'h3F};
    return {s, 5'(e), 6'(m)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic [11:0] av, input logic [11:0] bv,
                        input bit stray, input string tag);
    logic [11:0] expv;
    int exp_lat, n;
    bit was_done;
    expv    = ref_mul(av, bv);
    exp_lat = (av[10:6] == 0 || bv[10:6] == 0) ? 2 : 12;
    @(negedge clk);
    was_done = done;
    en = 1'b1; a = ~av; b = ~bv;          // junk on the strobe cycle (R2)
    @(posedge clk);
    @(negedge clk);
    en = 1'b0; a = av; b = bv;
    if (was_done) check(done == 1'b0, "R9", "done clears on strobe", done, 0);
    n = 0;
    while (!done && n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      en = 1'b0;
      if (n == 1) begin a = 12'($urandom); b = 12'($urandom); end  // R2 after capture
      if (stray && n == 5) begin en = 1'b1; a = 12'($urandom); b = 12'($urandom); end // R10
    end
    check(n == exp_lat, exp_lat == 2 ? "R7" : "R8", {tag, " latency"}, n, exp_lat);
    check(out == expv, tag, "result", int'(out), int'(expv));
    a = 12'($urandom); b = 12'($urandom);
    repeat (3) @(negedge clk);
    check(done && out == expv, "R9", "hold after done", int'(out), int'(expv));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(done == 1'b0 && out == 12'h000, "R1", "in reset", int'(out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && out == 12'h000, "R1", "after reset", int'(out), 0);

    run_op(12'h3C0, 12'h3C0, 1'b0, "R4");   // 1.0 * 1.0, no shift
    run_op(12'h3E0, 12'h3E0, 1'b0, "R4");   // 1.5 * 1.5, top bit set
    run_op(12'hBFF, 12'h3C1, 1'b0, "R3");   // negative times positive
    run_op(12'hBC0, 12'hBC0, 1'b0, "R3");   // negative times negative
    run_op(12'h041, 12'h852, 1'b0, "R5");   // underflow, signed zero
    run_op(12'h7BF, 12'h7A5, 1'b0, "R6");   // overflow saturation
    run_op(12'h801, 12'h3FF, 1'b0, "R7");   // zero exponent operand
    run_op(12'h5C3, 12'h000, 1'b0, "R7");
    run_op(12'h3D7, 12'h42A, 1'b1, "R10");  // stray strobe mid-multiply
    run_op(12'h3FF, 12'h3FF, 1'b0, "R11");  // largest significands

    for (int i = 0; i < 80; i++) begin
      logic [11:0] ra, rb;
      ra = 12'($urandom);
      rb = 12'($urandom);
      if (i % 3 == 0) begin ra[10:6] = 5'(12 + ($urandom % 8)); rb[10:6] = 5'(12 + ($urandom % 8)); end
      run_op(ra, rb, (i % 7 == 3) && ra[10:6] != 0 && rb[10:6] != 0, "R4");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule